// File: doc/BRIEF.md
# Free-Running Timer with Match Interrupts

This block keeps a 32-bit counter that runs freely at a fixed slow rate. A fractional prescaler derives that rate from the core clock. The rate is chosen at build time: 3.6864 MHz for one variant and 3.25 MHz for the other. Four channels each hold a 32-bit match value and compare it against the shared counter. When the counter steps onto a channel's match value and the channel is enabled, the channel latches an event and holds its own interrupt line high. Software clears an event by writing a one to that channel's bit in a shared status word.

Channel 3 also serves as a watchdog. Once software arms the watchdog, it cannot disarm it. After that, a channel 3 match raises a reset request toward the system reset controller, and only reset removes that request.

Software reaches every register through a simple word-addressed port that is synchronous to the core clock. A read returns its data one cycle later, and a read of an unmapped location also flags an error.

Top module: `fr_match_timer`

## Requirements
- R1: After reset, the counter, match values, enable mask, status bits, watchdog arm bit, interrupts and reset request are all zero.
- R2: The prescaler keeps an accumulator A that starts at 0. Each cycle it adds the rate: when A+RATE >= CLK_HZ, A becomes A+RATE-CLK_HZ and the tick register is 1 in the next cycle; otherwise A becomes A+RATE and the tick register is 0. The counter advances by one at each edge where the tick register is 1. RATE is 3686400 when VARIANT=0 and 3250000 when VARIANT=1.
- R3: A write to byte offset 0x10 loads the counter with the written word, and counting continues from that value. The load takes precedence over a tick in the same cycle, so the new value is not incremented at that edge.
- R4: Channel i (match value at byte offset 4*i, i = 0..3) raises an event only at the edge where the counter steps from match-1 to match and enable bit i is 1. At that same edge, status bit i and irq[i] become 1.
- R5: If enable bit i is 0, a match on channel i sets neither status bit i nor irq[i].
- R6: A write to the status word (offset 0x14) clears each status bit i, and drops irq[i], for every written bit i that is 1; bits written 0 leave their status unchanged. If a new event and a clear hit the same channel in the same cycle, the event wins and the bit stays 1.
- R7: The enable mask (offset 0x1C) stores only written bits 11..0, and reads return bits 31..12 as zero; bits 3..0 enable channels 3..0.
- R8: Writing offset 0x18 with bit 0 set arms the watchdog, and a write with bit 0 clear does nothing; the arm bit reads back at bit 0. While the watchdog is armed, a channel 3 match sets reset_req whatever the enable mask holds, and reset_req stays high until reset. With the watchdog disarmed, a channel 3 match leaves reset_req low.
- R9: When rd_en is high at an edge, rdata and rd_err are valid for the following cycle. An offset at or above 0x20, or one that is not a multiple of 4, reads as zero with rd_err high.
- R10: Loading the counter with a value equal to an enabled channel's match value does not raise that channel's event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| rd_err | output | 1 | Unmapped read flag, same cycle as rdata |
| irq | output | 4 | Per-channel interrupt levels |
| reset_req | output | 1 | Sticky watchdog reset request |

## Verification
The delicate case is a status clear that lands in the same cycle as a fresh match on that channel. The bench tracks the prescaler phase from reset and waits for the cycle in which the tick will move the counter onto channel 0's match value. It issues the status write in exactly that cycle, with channel 0's event already pending. The result is judged at the interrupt pin and in the read-back status word, both of which must still show the event. A plain clear made later must then drop it.

// File: rtl/frt_pkg.sv
package frt_pkg;

   localparam int unsigned RATE_VARIANT_A = 3_686_400;
   localparam int unsigned RATE_VARIANT_B = 3_250_000;

   // word index inside the 32-byte window
   localparam logic [2:0] IDX_COUNT  = 3'd4;
   localparam logic [2:0] IDX_STATUS = 3'd5;
   localparam logic [2:0] IDX_WDOG   = 3'd6;
   localparam logic [2:0] IDX_IEN    = 3'd7;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_MATCH,
      SEL_COUNT,
      SEL_STATUS,
      SEL_WDOG,
      SEL_IEN
   } sel_e;

   function automatic int unsigned rate_of(input bit variant);
      return variant ? RATE_VARIANT_B : RATE_VARIANT_A;
   endfunction

endpackage

// File: rtl/frt_tick_gen.sv
module frt_tick_gen #(
   parameter int unsigned CLK_HZ  = 125_000_000,
   parameter int unsigned RATE_HZ = 3_686_400
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);

   generate
      if (RATE_HZ >= CLK_HZ) begin : g_every_cycle
         always_ff @(posedge clk) begin
            if (rst) tick <= 1'b0;
            else     tick <= 1'b1;
         end
      end else begin : g_fractional
         localparam int ACC_W = $clog2(CLK_HZ + RATE_HZ) + 1;
         logic [ACC_W-1:0] acc_q;
         logic [ACC_W-1:0] sum;
         logic             wrap;

         always_comb begin
            sum  = acc_q + ACC_W'(RATE_HZ);
            wrap = (sum >= ACC_W'(CLK_HZ));
         end

         always_ff @(posedge clk) begin
            if (rst) begin
               acc_q <= '0;
               tick  <= 1'b0;
            end else begin
               acc_q <= wrap ? (sum - ACC_W'(CLK_HZ)) : sum;
               tick  <= wrap;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cnt_inc,
   output logic             step
);

   always_comb begin
      cnt_inc = cnt_q + CNT_W'(1);
      step    = tick && !load;
   end

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (load) cnt_q <= load_val;
      else if (step) cnt_q <= cnt_inc;
   end

endmodule

// File: rtl/frt_match_ch.sv
module frt_match_ch #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_match,
   input  logic [CNT_W-1:0] wdata,
   input  logic             step,
   input  logic [CNT_W-1:0] cnt_inc,
   input  logic             enable,
   input  logic             clear,
   output logic [CNT_W-1:0] match_q,
   output logic             hit,
   output logic             event_q
);

   always_comb begin
      hit = step && (cnt_inc == match_q);
   end

   always_ff @(posedge clk) begin
      if (rst)           match_q <= '0;
      else if (wr_match) match_q <= wdata;
   end

   // a fresh event outranks a simultaneous clear
   always_ff @(posedge clk) begin
      if (rst)                  event_q <= 1'b0;
      else if (hit && enable)   event_q <= 1'b1;
      else if (clear)           event_q <= 1'b0;
   end

endmodule

// File: rtl/fr_match_timer.sv
module fr_match_timer #(
   parameter int unsigned CLK_HZ  = 125_000_000,
   parameter bit          VARIANT = 1'b0,
   parameter int          CNT_W   = 32,
   parameter int          NUM_CH  = 4,
   parameter int          IEN_W   = 12,
   parameter int          ADDR_W  = 8,
   parameter int          WDOG_CH = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  wdata,
   output logic [CNT_W-1:0]  rdata,
   output logic              rd_err,
   output logic [NUM_CH-1:0] irq,
   output logic              reset_req
);
   import frt_pkg::*;

   localparam int unsigned RATE_HZ = rate_of(VARIANT);
   localparam int          CH_W    = $clog2(NUM_CH);

   generate
      if (NUM_CH != 4) begin : g_bad_ch
         $error("fr_match_timer: the address map holds exactly four channels");
      end
      if (IEN_W < NUM_CH || IEN_W > CNT_W) begin : g_bad_ien
         $error("fr_match_timer: enable mask width out of range");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("fr_match_timer: address must span at least 64 bytes");
      end
      if (WDOG_CH >= NUM_CH) begin : g_bad_wdog
         $error("fr_match_timer: watchdog channel does not exist");
      end
      if (CLK_HZ == 0) begin : g_bad_clk
         $error("fr_match_timer: clock rate must be nonzero");
      end
   endgenerate

   // ---------------- address decode ----------------
   sel_e            sel;
   logic [CH_W-1:0] ch;

   always_comb begin
      sel = SEL_NONE;
      ch  = addr[2 +: CH_W];
      if ((addr[ADDR_W-1:5] == '0) && (addr[1:0] == 2'b00)) begin
         case (addr[4:2])
            IDX_COUNT:  sel = SEL_COUNT;
            IDX_STATUS: sel = SEL_STATUS;
            IDX_WDOG:   sel = SEL_WDOG;
            IDX_IEN:    sel = SEL_IEN;
            default:    sel = SEL_MATCH;
         endcase
      end
   end

   logic load, wr_status, wr_wdog, wr_ien;
   always_comb begin
      load      = wr_en && (sel == SEL_COUNT);
      wr_status = wr_en && (sel == SEL_STATUS);
      wr_wdog   = wr_en && (sel == SEL_WDOG);
      wr_ien    = wr_en && (sel == SEL_IEN);
   end

   // ---------------- time base ----------------
   logic             tick;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_inc;
   logic             step;

   frt_tick_gen #(
      .CLK_HZ  (CLK_HZ),
      .RATE_HZ (RATE_HZ)
   ) u_tick (
      .clk  (clk),
      .rst  (rst),
      .tick (tick)
   );

   frt_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .load     (load),
      .load_val (wdata),
      .cnt_q    (cnt_q),
      .cnt_inc  (cnt_inc),
      .step     (step)
   );

   // ---------------- control registers ----------------
   logic [IEN_W-1:0]  ien_q;
   logic              wdog_q;
   logic              rreq_q;
   logic [NUM_CH-1:0] hit_v;
   logic [NUM_CH-1:0] event_v;
   logic [NUM_CH-1:0] clr_v;
   logic [NUM_CH-1:0][CNT_W-1:0] match_v;

   always_comb begin
      clr_v = wr_status ? wdata[NUM_CH-1:0] : '0;
   end

   always_ff @(posedge clk) begin
      if (rst)         ien_q <= '0;
      else if (wr_ien) ien_q <= wdata[IEN_W-1:0];
   end

   // arm-only watchdog and sticky reset request
   always_ff @(posedge clk) begin
      if (rst) begin
         wdog_q <= 1'b0;
         rreq_q <= 1'b0;
      end else begin
         if (wr_wdog && wdata[0])     wdog_q <= 1'b1;
         if (wdog_q && hit_v[WDOG_CH]) rreq_q <= 1'b1;
      end
   end

   // ---------------- match channels ----------------
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         frt_match_ch #(
            .CNT_W (CNT_W)
         ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_match (wr_en && (sel == SEL_MATCH) && (ch == CH_W'(i))),
            .wdata    (wdata),
            .step     (step),
            .cnt_inc  (cnt_inc),
            .enable   (ien_q[i]),
            .clear    (clr_v[i]),
            .match_q  (match_v[i]),
            .hit      (hit_v[i]),
            .event_q  (event_v[i])
         );
      end
   endgenerate

   // ---------------- read path ----------------
   logic [CNT_W-1:0] rd_val;
   logic             rd_bad;

   always_comb begin
      rd_val = '0;
      rd_bad = 1'b0;
      case (sel)
         SEL_MATCH:  rd_val = match_v[ch];
         SEL_COUNT:  rd_val = cnt_q;
         SEL_STATUS: rd_val = CNT_W'(event_v);
         SEL_WDOG:   rd_val = CNT_W'(wdog_q);
         SEL_IEN:    rd_val = CNT_W'(ien_q);
         default:    rd_bad = 1'b1;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rd_err <= 1'b0;
      end else begin
         rdata  <= rd_en ? rd_val : '0;
         rd_err <= rd_en && rd_bad;
      end
   end

   assign irq       = event_v;
   assign reset_req = rreq_q;

endmodule

// File: rtl/frt_checker.sv
module frt_checker #(
   parameter int CNT_W   = 32,
   parameter int NUM_CH  = 4,
   parameter int IEN_W   = 12,
   parameter int WDOG_CH = 3
) (
   input logic              clk,
   input logic              rst,
   input logic [CNT_W-1:0]  cnt,
   input logic              load,
   input logic [CNT_W-1:0]  ldval,
   input logic [NUM_CH-1:0] status,
   input logic [IEN_W-1:0]  ien,
   input logic [NUM_CH-1:0] hit,
   input logic [NUM_CH-1:0] clr,
   input logic              wdog,
   input logic              rreq,
   input logic              rd_err,
   input logic [CNT_W-1:0]  rdata
);

   // R2: without a load the counter holds or moves up by exactly one
   assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
      !$past(load) |-> (cnt == $past(cnt) || cnt == $past(cnt) + CNT_W'(1)));

   // R3: a load lands exactly, with no increment on top
   assert_count_load_R3: assert property (@(posedge clk) disable iff (rst)
      $past(load) |-> cnt == $past(ldval));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_chk
         // R4: an enabled step onto the match value leaves the event set
         assert_event_set_R4: assert property (@(posedge clk) disable iff (rst)
            $past(hit[i] && ien[i]) |-> status[i]);

         // R5: an event only appears with its enable bit set
         assert_event_needs_en_R5: assert property (@(posedge clk) disable iff (rst)
            $rose(status[i]) |-> $past(ien[i] && hit[i]));

         // R6: a clear without a competing event empties the bit
         assert_event_clear_R6: assert property (@(posedge clk) disable iff (rst)
            $past(clr[i] && !(hit[i] && ien[i])) |-> !status[i]);
      end
   endgenerate

   // R8: arm bit and reset request never fall outside reset
   assert_wdog_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      $past(wdog) |-> wdog);

   assert_rreq_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      $past(rreq) |-> rreq);

   assert_rreq_cause_R8: assert property (@(posedge clk) disable iff (rst)
      $rose(rreq) |-> $past(wdog && hit[WDOG_CH]));

   // R9: an erroring read returns zero
   assert_err_data_R9: assert property (@(posedge clk) disable iff (rst)
      rd_err |-> rdata == '0);

endmodule

bind fr_match_timer frt_checker #(
   .CNT_W   (CNT_W),
   .NUM_CH  (NUM_CH),
   .IEN_W   (IEN_W),
   .WDOG_CH (WDOG_CH)
) u_frt_checker (
   .clk    (clk),
   .rst    (rst),
   .cnt    (cnt_q),
   .load   (load),
   .ldval  (wdata),
   .status (event_v),
   .ien    (ien_q),
   .hit    (hit_v),
   .clr    (clr_v),
   .wdog   (wdog_q),
   .rreq   (rreq_q),
   .rd_err (rd_err),
   .rdata  (rdata)
);

// File: tb/test_fr_match_timer.sv
`timescale 1ns/1ps
module test_fr_match_timer;

   localparam longint CLK_HZ = 125_000_000;
   localparam longint RATE   = 3_686_400;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        wr_en = 1'b0;
   logic        rd_en = 1'b0;
   logic [7:0]  addr = 8'h00;
   logic [31:0] wdata = 32'h0;
   logic [31:0] rdata;
   logic        rd_err;
   logic [3:0]  irq;
   logic        reset_req;

   always #4 clk = ~clk;   // 125 MHz

   fr_match_timer i_fr_match_timer (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .rd_en     (rd_en),
      .addr      (addr),
      .wdata     (wdata),
      .rdata     (rdata),
      .rd_err    (rd_err),
      .irq       (irq),
      .reset_req (reset_req)
   );

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- reference model built from the requirements ----------------
   longint      m_acc;
   logic        m_tick;
   logic [31:0] m_cnt;
   logic [31:0] m_match [4];
   logic [11:0] m_ien;
   logic [3:0]  m_status;
   logic        m_wdog, m_rreq;
   logic [31:0] m_rd_cnt;
   int          mism = 0;

   always @(posedge clk) begin
      logic       ld;
      logic [3:0] h;
      ld = wr_en && addr == 8'h10;
      for (int i = 0; i < 4; i++)
         h[i] = m_tick && !ld && (m_cnt + 32'd1 == m_match[i]);
      if (rst) begin
         m_acc <= 0; m_tick <= 1'b0; m_cnt <= 32'h0; m_ien <= 12'h0;
         m_status <= 4'h0; m_wdog <= 1'b0; m_rreq <= 1'b0; m_rd_cnt <= 32'h0;
         for (int i = 0; i < 4; i++) m_match[i] <= 32'h0;
      end else begin
         if (m_acc + RATE >= CLK_HZ) begin m_acc <= m_acc + RATE - CLK_HZ; m_tick <= 1'b1; end
         else begin m_acc <= m_acc + RATE; m_tick <= 1'b0; end
         if (ld) m_cnt <= wdata;
         else if (m_tick) m_cnt <= m_cnt + 32'd1;
         for (int i = 0; i < 4; i++) begin
            if (wr_en && addr == 8'(4*i)) m_match[i] <= wdata;
            if (h[i] && m_ien[i]) m_status[i] <= 1'b1;
            else if (wr_en && addr == 8'h14 && wdata[i]) m_status[i] <= 1'b0;
         end
         if (wr_en && addr == 8'h1C) m_ien <= wdata[11:0];
         if (wr_en && addr == 8'h18 && wdata[0]) m_wdog <= 1'b1;
         if (m_wdog && h[3]) m_rreq <= 1'b1;
         if (rd_en) m_rd_cnt <= m_cnt;
      end
   end

   always @(negedge clk) begin
      if (!rst && (irq !== m_status || reset_req !== m_rreq)) mism++;
   end

   // ---------------- bus tasks (called at a falling edge) ----------------
   task automatic wr_now(input logic [7:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_now(a, d);
   endtask

   task automatic rd_now(input logic [7:0] a, output logic [31:0] v, output logic e);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata; e = rd_err;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v, output logic e);
      @(negedge clk);
      rd_now(a, v, e);
   endtask

   task automatic wait_cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // ---------------- register vectors ----------------
   typedef struct packed {
      logic        is_wr;
      logic [7:0]  a;
      logic [31:0] d;
      logic        err;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 8'h00, 32'h0000_1111, 1'b0},
      '{1'b1, 8'h04, 32'h2222_0000, 1'b0},
      '{1'b1, 8'h08, 32'hFFFF_FFFF, 1'b0},
      '{1'b1, 8'h0C, 32'h8000_0001, 1'b0},
      '{1'b0, 8'h00, 32'h0000_1111, 1'b0},   // R9 match read-back
      '{1'b0, 8'h04, 32'h2222_0000, 1'b0},
      '{1'b0, 8'h08, 32'hFFFF_FFFF, 1'b0},
      '{1'b0, 8'h0C, 32'h8000_0001, 1'b0},
      '{1'b1, 8'h1C, 32'hFFFF_F000, 1'b0},
      '{1'b0, 8'h1C, 32'h0000_0000, 1'b0},   // R7 upper bits dropped
      '{1'b1, 8'h1C, 32'h0000_0A50, 1'b0},
      '{1'b0, 8'h1C, 32'h0000_0A50, 1'b0},   // R7 low twelve kept
      '{1'b0, 8'h20, 32'h0000_0000, 1'b1},   // R9 beyond the window
      '{1'b0, 8'h02, 32'h0000_0000, 1'b1},   // R9 misaligned
      '{1'b0, 8'hFC, 32'h0000_0000, 1'b1},   // R9 far offset
      '{1'b1, 8'h1C, 32'h0000_0000, 1'b0}
   };

   logic [31:0] v;
   logic        e;

   initial begin : main
      bit coincided;
      wait_cycles(5);
      rst = 1'b0;

      // R1 reset state
      check("R1 irq", {28'h0, irq}, 32'h0);
      check("R1 reset_req", {31'h0, reset_req}, 32'h0);
      rd(8'h10, v, e); check("R1 count", v, m_rd_cnt); check("R1 count small", {31'h0, v > 32'd1}, 32'h0);
      rd(8'h14, v, e); check("R1 status", v, 32'h0);
      rd(8'h1C, v, e); check("R1 enable", v, 32'h0);
      rd(8'h18, v, e); check("R1 watchdog", v, 32'h0);
      rd(8'h0C, v, e); check("R1 match3", v, 32'h0);

      // vector walk: R7 and R9
      for (int k = 0; k < NV; k++) begin
         if (VECS[k].is_wr) wr(VECS[k].a, VECS[k].d);
         else begin
            rd(VECS[k].a, v, e);
            check(VECS[k].err ? "R9 unmapped data" : "R7/R9 read-back data", v, VECS[k].d);
            check("R9 error flag", {31'h0, e}, {31'h0, VECS[k].err});
         end
      end

      // R2 counting rate
      wr(8'h10, 32'h0);
      wait_cycles(3400);
      rd(8'h10, v, e);
      check("R2 count vs rate model", v, m_rd_cnt);
      check("R2 count near 100", {31'h0, (v >= 32'd99 && v <= 32'd101)}, 32'h1);

      // R3 load
      wr(8'h10, 32'h7FFF_FFF0);
      rd_now(8'h10, v, e);
      check("R3 loaded value", v, 32'h7FFF_FFF0);
      wait_cycles(200);
      rd(8'h10, v, e);
      check("R3 counting resumes", v, m_rd_cnt);
      // R3 load in a tick cycle
      for (int k = 0; k < 100; k++) begin
         if (m_tick) break;
         @(negedge clk);
      end
      wr_now(8'h10, 32'h0000_0400);
      rd_now(8'h10, v, e);
      check("R3 load beats tick", v, 32'h0000_0400);

      // R4 enabled match, edge-exact
      wr(8'h00, 32'h0000_0100);
      wr(8'h1C, 32'h0000_0001);
      wr(8'h10, 32'h0000_00FD);
      for (int k = 0; k < 400; k++) begin
         if (irq[0]) break;
         @(negedge clk);
      end
      check("R4 irq0 raised", {31'h0, irq[0]}, 32'h1);
      rd_now(8'h10, v, e);
      check("R4 count at event edge", v, 32'h0000_0100);
      rd(8'h14, v, e);
      check("R4 status bit0", v, 32'h1);

      // R5 disabled channel
      wr(8'h04, 32'h0000_0180);
      wr(8'h10, 32'h0000_017D);
      wait_cycles(300);
      check("R5 irq1 stays low", {31'h0, irq[1]}, 32'h0);
      rd(8'h10, v, e);
      check("R5 counter passed match", {31'h0, v > 32'h180}, 32'h1);
      rd(8'h14, v, e);
      check("R5 status bit1 clear", v, 32'h1);

      // R6 write-one-to-clear
      wr(8'h14, 32'h0000_0002);
      @(negedge clk);
      check("R6 zero bit no effect", {31'h0, irq[0]}, 32'h1);
      wr(8'h14, 32'h0000_0001);
      check("R6 one bit clears", {31'h0, irq[0]}, 32'h0);

      // R6 coincidence: set and clear in one cycle
      wr(8'h10, 32'h0000_00FD);
      for (int k = 0; k < 400; k++) begin
         if (irq[0]) break;
         @(negedge clk);
      end
      wr(8'h10, 32'h0000_00FD);
      coincided = 1'b0;
      for (int k = 0; k < 400; k++) begin
         if (m_tick && m_cnt == 32'h0000_00FF) begin
            wr_now(8'h14, 32'h0000_0001);
            coincided = 1'b1;
            break;
         end
         @(negedge clk);
      end
      check("R6 coincidence provoked", {31'h0, coincided}, 32'h1);
      check("R6 event wins over clear", {31'h0, irq[0]}, 32'h1);
      rd(8'h14, v, e);
      check("R6 status after coincidence", v, 32'h1);
      wr(8'h14, 32'h0000_000F);
      check("R6 later clear", {31'h0, irq[0]}, 32'h0);

      // R10 load onto a match value
      wr(8'h08, 32'h0000_0500);
      wr(8'h1C, 32'h0000_0004);
      wr(8'h10, 32'h0000_0500);
      wait_cycles(30);
      check("R10 no event from load", {31'h0, irq[2]}, 32'h0);

      // R8 watchdog
      wr(8'h1C, 32'h0000_0000);
      wr(8'h0C, 32'h0000_0700);
      wr(8'h10, 32'h0000_06FD);
      wait_cycles(300);
      check("R8 disarmed no request", {31'h0, reset_req}, 32'h0);
      wr(8'h18, 32'h0000_0000);
      rd(8'h18, v, e); check("R8 zero write ignored", v, 32'h0);
      wr(8'h18, 32'h0000_0001);
      rd(8'h18, v, e); check("R8 armed", v, 32'h1);
      wr(8'h18, 32'h0000_0000);
      rd(8'h18, v, e); check("R8 cannot disarm", v, 32'h1);
      wr(8'h10, 32'h0000_06FD);
      wait_cycles(300);
      check("R8 request raised", {31'h0, reset_req}, 32'h1);
      check("R8 irq3 stays low", {31'h0, irq[3]}, 32'h0);
      wr(8'h14, 32'h0000_000F);
      wait_cycles(3);
      check("R8 request sticky", {31'h0, reset_req}, 32'h1);

      // R4/R6/R8 pin tracking across the whole run
      check("R4 pins track model", mism, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : watchdog
      repeat (150_000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog timeout actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule